// File: doc/BRIEF.md
# Framed Serial ADC Word Receiver

This block is the receiving end of a serial converter link that shares one bit clock with its host. On each rising clock edge it samples a framing line and a serial data line. A frame opens with a marker that lasts one bit period. The active level of that marker is chosen by a configuration input. The bits that follow carry a two's-complement payload, most significant bit first. Once the whole payload has been shifted in, the block presents it as parallel words, sign-extended to 32 bits, together with a single-cycle valid strobe.

Two payload layouts are supported. The mode is latched when the marker is seen. In single mode the payload is one 18-bit sample. In dual mode it is 32 bits long: a 16-bit word for the first channel comes first, then a 16-bit word for the second channel. Between frames the sender drives a constant fill level on the data line, and the block ignores it. If a new marker arrives before a payload is complete, the partial frame is dropped, an error strobe is raised, and capture starts again from the new marker.

Top module: `sfr_word_rx`

## Requirements
- R1: While the reset input is low, and after it is released, `valid_o` and `err_o` are 0 and `word_o`, `chan_a_o` and `chan_b_o` are all zero until the first complete frame.
- R2: A marker is any clock edge at which `sync_i` equals `sync_pol_i` (1 means an active-high marker, 0 means an active-low marker). The inactive level never starts a frame.
- R3: In single mode (`cascade_i` = 0 at the marker), the 18 data bits sampled on the 18 edges after the marker form the sample, first bit = bit 17. `word_o` receives this sample sign-extended from bit 17 to 32 bits.
- R4: In dual mode (`cascade_i` = 1 at the marker), 32 bits are taken. The first 16 bits form channel A and the last 16 form channel B, each MSB first. Each channel is sign-extended from its bit 15 onto `chan_a_o` / `chan_b_o`, and both outputs update on the same edge.
- R5: If the marker is sampled at edge k and the payload has N bits, the outputs update at edge k+N and `valid_o` is 1 for exactly the one cycle after that edge.
- R6: Data bits sampled after a payload is complete and before the next marker cause no valid strobe and leave all outputs unchanged.
- R7: A marker sampled while a payload is incomplete gives no valid strobe for the aborted frame. `err_o` is 1 for the one cycle after that edge, and a new capture starts, with the next bit taken as its MSB.
- R8: The mode is taken from `cascade_i` only at the marker edge. Changing it during the payload has no effect on that frame.
- R9: A single-mode frame leaves `chan_a_o`/`chan_b_o` unchanged, and a dual-mode frame leaves `word_o` unchanged. No output word changes in a cycle without `valid_o`.
- R10: Full-scale codes map as follows. 18-bit 20000h becomes FFFE0000h and 1FFFFh becomes 0001FFFFh. 16-bit 8000h becomes FFFF8000h and 7FFFh becomes 00007FFFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_pol_i | input | 1 | Marker active level (1 = high, 0 = low) |
| cascade_i | input | 1 | Payload layout: 0 = one 18-bit sample, 1 = two 16-bit channels |
| sync_i | input | 1 | Serial framing line |
| data_i | input | 1 | Serial data line |
| word_o | output | 32 | Sign-extended single-mode sample |
| chan_a_o | output | 32 | Sign-extended first dual-mode channel |
| chan_b_o | output | 32 | Sign-extended second dual-mode channel |
| valid_o | output | 1 | One-cycle strobe: new result on the outputs |
| err_o | output | 1 | One-cycle strobe: a frame was aborted by an early marker |

## Verification
Single-mode frames carry the two full-scale codes and two mixed bit patterns. These show whether the sign comes from bit 17 and whether the bit order is MSB first. One of these frames uses an active-low marker, which shows that polarity selection works and that an idle-high framing line starts nothing. Dual-mode frames carry opposite-sign channel pairs, which show whether the 32 bits are split in the right place and each half is sign-extended separately. Other patterns cover the remaining cases: long runs of fill at both tag levels, a mode input that flips in the middle of a frame, and a marker that cuts off a partial payload. These separate real data from fill, latched mode from live mode, and abort-and-restart from plain continuation.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } sfr_state_e;

  function automatic int unsigned sfr_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sfr_rst_sync.sv
module sfr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/sfr_frame_ctrl.sv
module sfr_frame_ctrl
  import sfr_pkg::*;
#(
  parameter int unsigned NORM_BITS = 18,
  parameter int unsigned CASC_BITS = 32,
  parameter int unsigned CNT_W     = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic marker_i,
  input  logic cascade_i,
  output logic shift_en_o,
  output logic done_o,
  output logic abort_o,
  output logic mode_o
);
  sfr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mode_q, mode_d;
  logic [CNT_W-1:0] len;
  logic             last_bit;

  assign len      = mode_q ? CNT_W'(CASC_BITS) : CNT_W'(NORM_BITS);
  assign last_bit = (cnt_q == len - CNT_W'(1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    mode_d  = mode_q;
    if (marker_i) begin
      state_d = ST_SHIFT;
      cnt_d   = '0;
      mode_d  = cascade_i;
    end else if (state_q == ST_SHIFT) begin
      if (last_bit) begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_d;
    end
  end

  assign shift_en_o = (state_q == ST_SHIFT) && !marker_i;
  assign done_o     = shift_en_o && last_bit;
  assign abort_o    = (state_q == ST_SHIFT) && marker_i;
  assign mode_o     = mode_q;

  // R5: the bit counter never passes the payload length
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT) |-> (cnt_q < len));

  // R8: the latched mode only changes at a marker
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !marker_i |=> $stable(mode_q));
endmodule

// File: rtl/sfr_shifter.sv
module sfr_shifter #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] frame_o
);
  logic [WIDTH-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (en_i) sr_d = {sr_q[WIDTH-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign frame_o = sr_d;
endmodule

// File: rtl/sfr_sign_ext.sv
module sfr_sign_ext #(
  parameter int unsigned IN_W  = 18,
  parameter int unsigned OUT_W = 32
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o
);
  localparam int unsigned PAD_W = OUT_W - IN_W;

  generate
    if (PAD_W == 0) begin : g_same
      assign val_o = val_i;
    end else begin : g_pad
      assign val_o = {{PAD_W{val_i[IN_W-1]}}, val_i};
    end
  endgenerate
endmodule

// File: rtl/sfr_word_rx.sv
module sfr_word_rx
  import sfr_pkg::*;
#(
  parameter int unsigned NORM_BITS = 18,
  parameter int unsigned CHAN_BITS = 16,
  parameter int unsigned OUT_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_pol_i,
  input  logic             cascade_i,
  input  logic             sync_i,
  input  logic             data_i,
  output logic [OUT_W-1:0] word_o,
  output logic [OUT_W-1:0] chan_a_o,
  output logic [OUT_W-1:0] chan_b_o,
  output logic             valid_o,
  output logic             err_o
);
  localparam int unsigned CASC_BITS = 2 * CHAN_BITS;
  localparam int unsigned FRAME_W   = sfr_max(NORM_BITS, CASC_BITS);
  localparam int unsigned CNT_W     = $clog2(FRAME_W + 1);
  localparam int unsigned N_CHAN    = 2;

  logic               rst_n_s;
  logic               marker;
  logic               shift_en, done, abort, mode;
  logic [FRAME_W-1:0] frame;
  logic [OUT_W-1:0]   norm_ext;
  logic [OUT_W-1:0]   chan_ext [N_CHAN];

  logic [OUT_W-1:0] word_q, word_d, cha_q, cha_d, chb_q, chb_d;
  logic             valid_q, valid_d, err_q, err_d;
  logic             word_en, casc_en;

  sfr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  assign marker = (sync_i == sync_pol_i);

  sfr_frame_ctrl #(
    .NORM_BITS (NORM_BITS),
    .CASC_BITS (CASC_BITS),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .marker_i   (marker),
    .cascade_i  (cascade_i),
    .shift_en_o (shift_en),
    .done_o     (done),
    .abort_o    (abort),
    .mode_o     (mode)
  );

  sfr_shifter #(.WIDTH(FRAME_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .en_i    (shift_en),
    .bit_i   (data_i),
    .frame_o (frame)
  );

  sfr_sign_ext #(.IN_W(NORM_BITS), .OUT_W(OUT_W)) u_sx_norm (
    .val_i (frame[NORM_BITS-1:0]),
    .val_o (norm_ext)
  );

  // index 0 = later (low) half, index 1 = earlier (high) half
  for (genvar gi = 0; gi < N_CHAN; gi++) begin : g_chan
    sfr_sign_ext #(.IN_W(CHAN_BITS), .OUT_W(OUT_W)) u_sx_chan (
      .val_i (frame[gi*CHAN_BITS +: CHAN_BITS]),
      .val_o (chan_ext[gi])
    );
  end

  assign word_en = done && !mode;
  assign casc_en = done && mode;

  always_comb begin
    word_d  = word_q;
    cha_d   = cha_q;
    chb_d   = chb_q;
    valid_d = done;
    err_d   = abort;
    if (word_en) word_d = norm_ext;
    if (casc_en) begin
      cha_d = chan_ext[1];
      chb_d = chan_ext[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      word_q  <= '0;
      cha_q   <= '0;
      chb_q   <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      word_q  <= word_d;
      cha_q   <= cha_d;
      chb_q   <= chb_d;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign word_o   = word_q;
  assign chan_a_o = cha_q;
  assign chan_b_o = chb_q;
  assign valid_o  = valid_q;
  assign err_o    = err_q;

  // R5: valid is a single-cycle strobe
  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n_s)
    valid_o |=> !valid_o);

  // R7: an aborted frame never delivers a result at the same time
  a_r7_err_no_valid: assert property (@(posedge clk) disable iff (!rst_n_s)
    err_o |-> !valid_o);

  // R9: result words only move together with a valid strobe
  a_r9_word_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    !($stable(word_o) && $stable(chan_a_o) && $stable(chan_b_o)) |-> valid_o);

  // R3: the single-mode word is always a proper sign extension
  a_r3_norm_sext: assert property (@(posedge clk) disable iff (!rst_n_s)
    (word_o[OUT_W-1:NORM_BITS-1] == '0) || (&word_o[OUT_W-1:NORM_BITS-1]));

  // R4: each channel word is always a proper sign extension
  a_r4_chan_sext: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((chan_a_o[OUT_W-1:CHAN_BITS-1] == '0) || (&chan_a_o[OUT_W-1:CHAN_BITS-1])) &&
    ((chan_b_o[OUT_W-1:CHAN_BITS-1] == '0) || (&chan_b_o[OUT_W-1:CHAN_BITS-1])));
endmodule

// File: tb/sfr_word_rx_bench.sv
module sfr_word_rx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_pol_i = 1'b1;
  logic        cascade_i = 1'b0;
  logic        sync_i = 1'b0;
  logic        data_i = 1'b0;
  logic [31:0] word_o, chan_a_o, chan_b_o;
  logic        valid_o, err_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sfr_word_rx u_sfr_word_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_pol_i (sync_pol_i),
    .cascade_i  (cascade_i),
    .sync_i     (sync_i),
    .data_i     (data_i),
    .word_o     (word_o),
    .chan_a_o   (chan_a_o),
    .chan_b_o   (chan_b_o),
    .valid_o    (valid_o),
    .err_o      (err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sx18(input logic [17:0] v);
    return {{14{v[17]}}, v};
  endfunction

  function automatic logic [31:0] sx16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  // Marker, then payload MSB first; checks err at first bit, then the result.
  task automatic send_frame(input string req, input logic pol, input logic casc,
                            input logic [31:0] pay, input logic tag,
                            input logic flip, input logic exp_err);
    int nbits;
    logic [31:0] w0, a0, b0;
    nbits = casc ? 32 : 18;
    @(negedge clk);
    w0 = word_o; a0 = chan_a_o; b0 = chan_b_o;
    sync_pol_i = pol; sync_i = pol; data_i = tag; cascade_i = casc;
    for (int i = nbits - 1; i >= 0; i--) begin
      @(negedge clk);
      if (i == nbits - 1) chk({req, " R7 err"}, {31'd0, err_o}, {31'd0, exp_err});
      if (i == 0) chk({req, " R5 valid early"}, {31'd0, valid_o}, 32'd0);
      sync_i = ~pol; data_i = pay[i];
      if (i == nbits - 1 && flip) cascade_i = ~casc;
    end
    @(negedge clk);
    chk({req, " R5 valid"}, {31'd0, valid_o}, 32'd1);
    if (!casc) begin
      chk({req, " R3 word"}, word_o, sx18(pay[17:0]));
      chk({req, " R9 chan_a hold"}, chan_a_o, a0);
      chk({req, " R9 chan_b hold"}, chan_b_o, b0);
    end else begin
      chk({req, " R4 chan_a"}, chan_a_o, sx16(pay[31:16]));
      chk({req, " R4 chan_b"}, chan_b_o, sx16(pay[15:0]));
      chk({req, " R9 word hold"}, word_o, w0);
    end
    sync_i = ~pol; data_i = tag; cascade_i = 1'b0;
    @(negedge clk);
    chk({req, " R5 valid one cycle"}, {31'd0, valid_o}, 32'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {31'd0, valid_o}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 valid", {31'd0, valid_o}, 32'd0);
    chk("R1 err", {31'd0, err_o}, 32'd0);
    chk("R1 word", word_o, 32'd0);
    chk("R1 chan_a", chan_a_o, 32'd0);
    chk("R1 chan_b", chan_b_o, 32'd0);
  endtask

  task automatic t_single();
    send_frame("R10 neg full", 1'b1, 1'b0, 32'h0002_0000, 1'b0, 1'b0, 1'b0);
    chk("R10 neg full value", word_o, 32'hFFFE_0000);
    send_frame("R10 pos full", 1'b1, 1'b0, 32'h0001_FFFF, 1'b1, 1'b0, 1'b0);
    chk("R10 pos full value", word_o, 32'h0001_FFFF);
    send_frame("R3 mixed", 1'b1, 1'b0, 32'h0002_A5C3, 1'b0, 1'b0, 1'b0);
    send_frame("R2 low marker", 1'b0, 1'b0, 32'h0001_5A3C, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_fill(input logic pol, input logic tag);
    logic [31:0] w0, a0, b0;
    int seen;
    seen = 0;
    @(negedge clk);
    sync_pol_i = pol; sync_i = ~pol; data_i = tag;
    w0 = word_o; a0 = chan_a_o; b0 = chan_b_o;
    repeat (40) begin
      @(negedge clk);
      if (valid_o || err_o) seen++;
      data_i = ~data_i;
    end
    data_i = tag;
    chk("R6 no strobe during fill", seen, 0);
    chk("R6 word held", word_o, w0);
    chk("R6 chan_a held", chan_a_o, a0);
    chk("R6 chan_b held", chan_b_o, b0);
  endtask

  task automatic t_cascade();
    send_frame("R10 casc full", 1'b1, 1'b1, 32'h8000_7FFF, 1'b0, 1'b0, 1'b0);
    chk("R10 chan_a full", chan_a_o, 32'hFFFF_8000);
    chk("R10 chan_b full", chan_b_o, 32'h0000_7FFF);
    send_frame("R4 mixed", 1'b0, 1'b1, 32'h1234_FEDC, 1'b1, 1'b0, 1'b0);
    send_frame("R8 casc flip", 1'b1, 1'b1, 32'hC001_3FFE, 1'b0, 1'b1, 1'b0);
    send_frame("R8 single flip", 1'b1, 1'b0, 32'h0003_0F0F, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_abort();
    logic [31:0] w0;
    @(negedge clk);
    w0 = word_o;
    sync_pol_i = 1'b1; sync_i = 1'b1; data_i = 1'b0; cascade_i = 1'b0;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      sync_i = 1'b0; data_i = 1'b1;
    end
    send_frame("R7 restart", 1'b1, 1'b0, 32'h0000_1357, 1'b0, 1'b0, 1'b1);
    chk("R7 restart value", word_o, 32'h0000_1357);
    chk("R7 not old", {31'd0, (word_o == w0)}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single();
    t_fill(1'b0, 1'b1);
    t_fill(1'b1, 1'b0);
    t_cascade();
    t_fill(1'b1, 1'b1);
    t_abort();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule